// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a single-request host port and an external byte-wide asynchronous static RAM. It turns each host read or write into a pin sequence that meets the memory's minimum intervals. Those intervals are given in nanoseconds as parameters and converted to clock counts with a ceiling division. The memory is selected through two enables of opposite polarity, one active low and one active high. Reads are gated by an active-low output enable and writes by an active-low write enable.

The data bus is presented as separate outgoing value, drive-enable and incoming value, so the pad ring can build the tri-state buffer. A request is taken when `req` is high while the sequencer is idle; `wr` selects a write. The address and write data are sampled at that edge. Completion is a single-cycle `ack`, and for a read `rdata` is valid from that cycle. The host drops `req` on seeing `ack`. Each operation is followed by a recovery interval with the memory deselected.

Top module: `sram_seq`

## Requirements
- R1: After reset and while idle: `mem_cs_lo_n`=1, `mem_cs_hi`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `ack`=0.
- R2: A write of value D to address A, followed by a read of A, returns D on `rdata`.
- R3: `mem_we_n` is low only while both selects are active. Each low pulse lasts at least WP_CYC = max(ceil(WP_NS/CLK_NS), ceil(DS_NS/CLK_NS), ceil(CW_NS/CLK_NS)-1) cycles. The memory is selected for at least ceil(CW_NS/CLK_NS) cycles up to the rising edge of `mem_we_n`.
- R4: Before each rising edge of `mem_we_n`, `mem_dq_oe` is high and `mem_dq_out` is unchanged for at least ceil(DS_NS/CLK_NS) cycles. In the cycle after that edge, the same value is still driven.
- R5: `mem_addr` does not change while `mem_we_n` is low.
- R6: A read holds `mem_oe_n` low, with `mem_we_n` high and the memory selected, for at least ceil(ACC_NS/CLK_NS) cycles. `rdata` is the bus value from the last of those cycles.
- R7: `mem_dq_oe` and a low `mem_oe_n` never coincide, and `mem_dq_oe` is low in the cycle before `mem_oe_n` falls.
- R8: Each accepted request yields exactly one `ack`, high for one cycle.
- R9: Between two operations the memory stays deselected for at least ceil(REC_NS/CLK_NS) cycles.
- R10: The full 17-bit address range is reachable: addresses 0 and 0x1FFFF hold independent data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, sampled while idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Host byte address |
| wdata | input | 8 | Host write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with ack |
| mem_addr | output | 17 | Memory address pins |
| mem_cs_lo_n | output | 1 | Active-low memory select |
| mem_cs_hi | output | 1 | Active-high memory select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data from the memory bus |

## Verification
The embedded assertions assume `rst` is high from time zero. They also assume the host lowers `req` in the cycle it sees `ack`, before the recovery interval ends, so one request never starts two operations. The stimulus issues each operation through a task that holds `req` until `ack` and then drops it at once. Random addresses come from a small pool that includes both range ends, so reads often hit written locations. A bus model in the bench drives `mem_dq_in` only while the memory is selected for reading.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WPUL,
        ST_WEND,
        ST_RSET,
        ST_RACC,
        ST_REC
    } seq_st_e;

    typedef struct packed {
        logic cs_lo_n;
        logic cs_hi;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STROBE_QUIET = '{cs_lo_n: 1'b1, cs_hi: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    // Nanoseconds to clock cycles, rounded up, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Pin pattern held for each sequencer state.
    function automatic strobe_t strobe_of(input seq_st_e s);
        strobe_t p;
        p = STROBE_QUIET;
        case (s)
            ST_WSET: begin p.cs_lo_n = 1'b0; p.cs_hi = 1'b1; end
            ST_WPUL: begin p.cs_lo_n = 1'b0; p.cs_hi = 1'b1; p.we_n = 1'b0; p.dq_oe = 1'b1; end
            ST_WEND: begin p.cs_lo_n = 1'b0; p.cs_hi = 1'b1; p.dq_oe = 1'b1; end
            ST_RSET: begin p.cs_lo_n = 1'b0; p.cs_hi = 1'b1; end
            ST_RACC: begin p.cs_lo_n = 1'b0; p.cs_hi = 1'b1; p.oe_n = 1'b0; end
            default: p = STROBE_QUIET;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R3 the counter only moves down between loads
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int WP_CYC  = 8,
    parameter int ACC_CYC = 9,
    parameter int REC_CYC = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             wr,
    input  logic             tmr_zero,
    output seq_st_e          st_nxt,
    output logic             accept,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             finish,
    output logic             capture
);
    localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] ACC_LD = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);

    seq_st_e st_q;

    always_comb begin
        st_nxt   = st_q;
        accept   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        finish   = 1'b0;
        capture  = 1'b0;
        case (st_q)
            ST_IDLE: if (req) begin
                accept = 1'b1;
                st_nxt = wr ? ST_WSET : ST_RSET;
            end
            ST_WSET: begin
                st_nxt   = ST_WPUL;
                tmr_load = 1'b1;
                tmr_val  = WP_LD;
            end
            ST_WPUL: if (tmr_zero) st_nxt = ST_WEND;
            ST_WEND: begin
                st_nxt   = ST_REC;
                tmr_load = 1'b1;
                tmr_val  = REC_LD;
                finish   = 1'b1;
            end
            ST_RSET: begin
                st_nxt   = ST_RACC;
                tmr_load = 1'b1;
                tmr_val  = ACC_LD;
            end
            ST_RACC: if (tmr_zero) begin
                st_nxt   = ST_REC;
                tmr_load = 1'b1;
                tmr_val  = REC_LD;
                finish   = 1'b1;
                capture  = 1'b1;
            end
            ST_REC:  if (tmr_zero) st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_nxt;
    end

    // R9 recovery always ends in idle, never straight into a new select
    rec_exit_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == ST_REC && st_q != ST_REC) |-> (st_q == ST_IDLE));

    // R8 a new request is taken only from idle
    accept_idle_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> (st_q == ST_IDLE));
endmodule

// File: rtl/sram_seq_strobe.sv
module sram_seq_strobe
    import sram_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  seq_st_e st_nxt,
    output strobe_t pins
);
    // Registered so no decode glitch ever reaches an asynchronous strobe.
    always_ff @(posedge clk) begin
        if (rst) pins <= STROBE_QUIET;
        else     pins <= strobe_of(st_nxt);
    end

    // R7
    no_fight_chk: assert property (@(posedge clk) disable iff (rst)
        !(pins.dq_oe && !pins.oe_n));

    // R7
    release_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pins.oe_n) |-> !$past(pins.dq_oe));

    // R3
    we_selected_chk: assert property (@(posedge clk) disable iff (rst)
        !pins.we_n |-> (!pins.cs_lo_n && pins.cs_hi));
endmodule

// File: rtl/sram_seq_datapath.sv
module sram_seq_datapath #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              finish,
    input  logic              capture,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              ack_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            ack_q   <= 1'b0;
        end else begin
            ack_q <= finish;
            if (capture) rdata_q <= dq_in;
        end
    end

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!we_n && $past(!we_n)) |-> $stable(addr_q));

    // R8
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        ack_q |=> !ack_q);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int CLK_NS = 8,
    parameter int WP_NS  = 50,
    parameter int DS_NS  = 30,
    parameter int CW_NS  = 70,
    parameter int ACC_NS = 70,
    parameter int REC_NS = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_lo_n,
    output logic              mem_cs_hi,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int CW_CYC  = int'(ns_to_cyc(CW_NS, CLK_NS));
    localparam int WP_CYC  = int'(umax(umax(ns_to_cyc(WP_NS, CLK_NS), ns_to_cyc(DS_NS, CLK_NS)),
                                       (CW_CYC > 1) ? CW_CYC - 1 : 1));
    localparam int ACC_CYC = int'(ns_to_cyc(ACC_NS, CLK_NS));
    localparam int REC_CYC = int'(ns_to_cyc(REC_NS, CLK_NS));
    localparam int MAX_CYC = int'(umax(umax(WP_CYC, ACC_CYC), REC_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_st_e          st_nxt;
    logic             accept, tmr_load, tmr_zero, finish, capture;
    logic [CNT_W-1:0] tmr_val;
    strobe_t          pins;

    sram_seq_fsm #(
        .CNT_W  (CNT_W),
        .WP_CYC (WP_CYC),
        .ACC_CYC(ACC_CYC),
        .REC_CYC(REC_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .wr      (wr),
        .tmr_zero(tmr_zero),
        .st_nxt  (st_nxt),
        .accept  (accept),
        .tmr_load(tmr_load),
        .tmr_val (tmr_val),
        .finish  (finish),
        .capture (capture)
    );

    sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    sram_seq_strobe u_strobe (
        .clk   (clk),
        .rst   (rst),
        .st_nxt(st_nxt),
        .pins  (pins)
    );

    sram_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .finish  (finish),
        .capture (capture),
        .we_n    (pins.we_n),
        .addr_in (addr),
        .wdata_in(wdata),
        .dq_in   (mem_dq_in),
        .addr_q  (mem_addr),
        .wdata_q (mem_dq_out),
        .rdata_q (rdata),
        .ack_q   (ack)
    );

    assign mem_cs_lo_n = pins.cs_lo_n;
    assign mem_cs_hi   = pins.cs_hi;
    assign mem_we_n    = pins.we_n;
    assign mem_oe_n    = pins.oe_n;
    assign mem_dq_oe   = pins.dq_oe;

    // R1 no completion while deselected and not just finished
    quiet_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !$past(ack)) |-> (mem_cs_lo_n && !mem_cs_hi));

    // R6 a read strobe never overlaps a write strobe
    read_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_we_n && !mem_cs_lo_n && mem_cs_hi));
endmodule

// File: tb/sram_seq_test.sv
module sram_seq_test;
    localparam int CLK_NS = 8;
    localparam int WP_C   = 7;   // ceil(50/8)
    localparam int DS_C   = 4;   // ceil(30/8)
    localparam int CW_C   = 9;   // ceil(70/8)
    localparam int ACC_C  = 9;   // ceil(70/8)
    localparam int REC_C  = 5;   // ceil(40/8)
    localparam int WPX_C  = (WP_C > CW_C - 1) ? WP_C : CW_C - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0, wr = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ack;
    logic [7:0]  rdata;
    logic [16:0] mem_addr;
    logic        mem_cs_lo_n, mem_cs_hi, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'h5A;

    int total = 0, bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sram_seq uut (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
        .ack(ack), .rdata(rdata), .mem_addr(mem_addr), .mem_cs_lo_n(mem_cs_lo_n),
        .mem_cs_hi(mem_cs_hi), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    logic [7:0] model_mem [int];
    logic [7:0] exp_mem   [int];

    function automatic logic [7:0] fill_val(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {7'b0, a[16]} ^ 8'h3C;
    endfunction

    function automatic logic [7:0] model_rd(input logic [16:0] a);
        return model_mem.exists(int'(a)) ? model_mem[int'(a)] : fill_val(a);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [16:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : fill_val(a);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Pin monitor and memory model, sampled mid-cycle.
    int we_lo_run = 0, sel_run = 0, drv_run = 0, oe_lo_run = 0, desel_run = 1000;
    logic prev_we_n = 1, prev_sel = 0, prev_oe_n = 1, prev_dq_oe = 0;
    logic [7:0]  prev_dq = '0;
    logic [16:0] prev_addr = '0;
    bit addr_moved = 0;

    always @(negedge clk) begin
        if (!rst) begin
            automatic logic sel = !mem_cs_lo_n && mem_cs_hi;
            if (!mem_we_n && !prev_we_n && mem_addr != prev_addr) addr_moved = 1;
            if (prev_we_n == 0 && mem_we_n == 1) begin
                chk(we_lo_run >= WPX_C, "R3 we pulse", we_lo_run, WPX_C);
                chk(sel_run >= CW_C, "R3 select to end", sel_run, CW_C);
                chk(drv_run >= DS_C, "R4 data setup", drv_run, DS_C);
                chk(mem_dq_oe && mem_dq_out == prev_dq, "R4 data hold", mem_dq_out, prev_dq);
                chk(!addr_moved, "R5 addr stable", mem_addr, prev_addr);
                addr_moved = 0;
                model_mem[int'(mem_addr)] = mem_dq_out;
            end
            if (sel && !prev_sel)
                chk(desel_run >= REC_C, "R9 recovery", desel_run, REC_C);
            if (!mem_oe_n && prev_oe_n)
                chk(!prev_dq_oe, "R7 release before oe", prev_dq_oe, 0);
            if (mem_oe_n && !prev_oe_n)
                chk(oe_lo_run >= ACC_C, "R6 access length", oe_lo_run, ACC_C);
            if (!mem_oe_n)
                chk(!mem_dq_oe && mem_we_n && sel, "R7 contention", mem_dq_oe, 0);

            we_lo_run = mem_we_n ? 0 : we_lo_run + 1;
            sel_run   = sel ? sel_run + 1 : 0;
            desel_run = sel ? 0 : desel_run + 1;
            oe_lo_run = mem_oe_n ? 0 : oe_lo_run + 1;
            drv_run   = (mem_dq_oe && (drv_run == 0 || mem_dq_out == prev_dq)) ? drv_run + 1 :
                        (mem_dq_oe ? 1 : 0);
            prev_we_n = mem_we_n; prev_sel = sel; prev_oe_n = mem_oe_n;
            prev_dq_oe = mem_dq_oe; prev_dq = mem_dq_out; prev_addr = mem_addr;
            mem_dq_in = (sel && mem_we_n && !mem_oe_n) ? model_rd(mem_addr) : 8'h5A;
        end
    end

    task automatic do_op(input bit is_wr, input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        req = 1; wr = is_wr; addr = a; wdata = d;
        do @(negedge clk); while (!ack);
        req = 0; wr = 0;
        if (is_wr) exp_mem[int'(a)] = d;
        else chk(rdata == exp_rd(a), "R2 R10 read data", rdata, exp_rd(a));
        @(negedge clk);
        chk(!ack, "R8 ack one cycle", ack, 0);
    endtask

    task automatic chk_quiet(input string tag);
        chk(mem_cs_lo_n && !mem_cs_hi && mem_we_n && mem_oe_n && !mem_dq_oe && !ack,
            tag, {mem_cs_lo_n, mem_cs_hi, mem_we_n, mem_oe_n, mem_dq_oe, ack}, 6'b101100);
    endtask

    initial begin
        logic [16:0] pool [16];
        void'($urandom(32'd7));
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk_quiet("R1 reset state");
        rst = 0;
        repeat (3) @(negedge clk);
        chk_quiet("R1 idle after reset");

        // R10 both ends of the address range
        do_op(1, 17'h00000, 8'hA1);
        do_op(1, 17'h1FFFF, 8'h7E);
        do_op(0, 17'h00000, 8'h00);
        do_op(0, 17'h1FFFF, 8'h00);
        // R2 unwritten location and overwrite
        do_op(0, 17'h0ABCD, 8'h00);
        do_op(1, 17'h0ABCD, 8'hFF);
        do_op(1, 17'h0ABCD, 8'h00);
        do_op(0, 17'h0ABCD, 8'h00);

        for (int i = 0; i < 16; i++) pool[i] = 17'($urandom);
        pool[0] = 17'h00000; pool[1] = 17'h1FFFF;
        for (int i = 0; i < 300; i++) begin
            automatic bit w = $urandom_range(0, 1) == 1;
            do_op(w, pool[$urandom_range(0, 15)], 8'($urandom));
            if ($urandom_range(0, 7) == 0) repeat ($urandom_range(1, 6)) @(negedge clk);
        end

        repeat (REC_C + 2) @(negedge clk);
        chk_quiet("R1 idle after traffic");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule